// File: doc/BRIEF.md
# Two-Way Data Cache Tag and Replacement Controller

This block holds the tags and line state for a small two-way set-associative data cache. Each access names a set with bits of the virtual address and compares against a stored physical tag. A hit is answered one cycle after the request is accepted, together with the way that matched. On a miss the block picks a way to replace. It issues a writeback request if that way holds modified data, then a refill request. It waits for the refill-done strobe and then releases the requester. The data array, the bus sequencing of the refill and the address translation live outside this block.

Every access carries its own write-policy bit taken from its page. Writes to write-back pages mark a line modified. Writes to write-through pages never do, and are forwarded to the bus as a one-cycle strobe. A per-way lock register keeps chosen ways resident: replacement never picks a locked way. With both ways locked, a miss is refilled without being installed. The lock register is written through a small write port and is not cleared by reset. The replacement choice among unlocked ways uses one recency bit per set.

Top module: `dcache_tag_ctrl`

## Requirements
- R1: After reset all lines are invalid and all recency bits select way 0. ready is 1 and resp_valid, wb_req, fill_req and bus_wr are 0. The first lookup of any set misses.
- R2: A request accepted while ready is 1 whose set holds a valid line with an equal tag gives resp_valid=1, resp_hit=1 and resp_way = the matching way on the next cycle, with no writeback or refill request.
- R3: A line is found only when both its set index and its tag match. The same tag at another index misses.
- R4: Each set has one recency bit. After a hit in way w, or an install into way w, the next victim at that set among unlocked ways is the other way.
- R5: lock_wdata bit w = 1 locks way w. A locked way is never the victim: with exactly one way locked, the other way is always replaced and fill_alloc is 1.
- R6: With both ways locked, a miss raises fill_req with fill_alloc=0 and installs nothing, so the same access misses again and resident lines still hit.
- R7: A write with req_wt=0 marks its line modified, on a hit or on the install after a miss. Evicting a modified line raises wb_req with wb_tag and wb_index equal to the old line's tag and set.
- R8: A write with req_wt=1 gives bus_wr=1 for one cycle, the cycle after acceptance, on a hit or a miss. It never marks a line modified, so a later eviction of that line raises no wb_req.
- R9: wb_req lasts exactly one cycle and is followed directly by fill_req. The two are never high together, and a clean victim goes straight to fill_req.
- R10: fill_req, fill_tag, fill_index, fill_way and fill_alloc hold until fill_done is seen. On the next cycle resp_valid=1, resp_hit=0, fill_req=0 and ready=1.
- R11: A request presented while ready is 0 is ignored: it produces no bus_wr and no response.
- R12: The lock register changes only on lock_we and keeps its value through reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lock_we | input | 1 | Write strobe for the way-lock register |
| lock_wdata | input | 2 | New lock bits, bit w locks way w |
| req_valid | input | 1 | Access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wt | input | 1 | Page policy: 1 = write-through, 0 = write-back |
| req_index | input | IDX_W | Set index from virtual address bits |
| req_tag | input | TAG_W | Physical tag |
| ready | output | 1 | Idle, a request will be accepted |
| resp_valid | output | 1 | One-cycle completion pulse |
| resp_hit | output | 1 | Completion was a hit |
| resp_way | output | 1 | Way that hit or was filled |
| bus_wr | output | 1 | Forward a write-through write to the bus |
| wb_req | output | 1 | Write back the victim line |
| wb_tag | output | TAG_W | Tag of the line being written back |
| wb_index | output | IDX_W | Set of the line being written back |
| fill_req | output | 1 | Refill request, held until fill_done |
| fill_tag | output | TAG_W | Tag being fetched |
| fill_index | output | IDX_W | Set being fetched |
| fill_way | output | 1 | Way that receives the line |
| fill_alloc | output | 1 | 1 = the line is installed, 0 = no way free |
| fill_done | input | 1 | First doubleword of the refill has arrived |

## Verification
The lookup path is exercised by a sequence of reads and writes that revisits one set with changing tags. This separates hits from misses, shows which way the recency bit picks, and shows whether a modified victim produces a writeback carrying its old tag. Writes with each policy bit are mixed into the same set. A write-through write that wrongly marked its line would show up as a writeback on a later eviction. A repeated tag at a second index tells set selection apart from tag comparison. Lock patterns with one way and with both ways locked, a request held high while the block is busy, and a reset with the lock register already programmed cover the replacement and retention rules.

// File: rtl/dct_pkg.sv
// Shared definitions for the two-way data cache tag controller.
// Assumes exactly two ways; the victim selector is written for that.
package dct_pkg;
    localparam int NUM_WAYS = 2;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WB   = 2'd1,
        ST_FILL = 2'd2
    } dct_state_e;
endpackage

// File: rtl/dct_tag_way.sv
// One way of the tag store: tag, valid and modified bit per set.
// Lookup is combinational on look_index/look_tag. An install writes the tag,
// sets valid and loads the modified bit. A mark sets the modified bit at the
// lookup index. Assumes install and mark are never requested together.
module dct_tag_way #(
    parameter int IDX_W = 4,
    parameter int TAG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] look_index,
    input  logic [TAG_W-1:0] look_tag,
    output logic             look_hit,
    output logic             look_dirty,
    output logic [TAG_W-1:0] look_tag_q,
    input  logic             inst_en,
    input  logic [IDX_W-1:0] inst_index,
    input  logic [TAG_W-1:0] inst_tag,
    input  logic             inst_dirty,
    input  logic             mark_en
);
    localparam int SETS = 1 << IDX_W;

    logic [TAG_W-1:0] tag_q [SETS];
    logic [SETS-1:0]  valid_q;
    logic [SETS-1:0]  dirty_q;

    // Line state: cleared by reset, loaded on install, modified on mark.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            dirty_q <= '0;
        end else if (inst_en) begin
            valid_q[inst_index] <= 1'b1;
            dirty_q[inst_index] <= inst_dirty;
        end else if (mark_en) begin
            dirty_q[look_index] <= 1'b1;
        end
    end

    // Tag storage: only meaningful where valid, so it needs no reset.
    always_ff @(posedge clk) begin
        if (inst_en) begin
            tag_q[inst_index] <= inst_tag;
        end
    end

    // Lookup compare for the presented set.
    always_comb begin
        look_tag_q = tag_q[look_index];
        look_hit   = valid_q[look_index] && (tag_q[look_index] == look_tag);
        look_dirty = dirty_q[look_index];
    end
endmodule

// File: rtl/dct_lru.sv
// One recency bit per set; the bit names the way to replace next.
// An update records that used_way was just touched.
module dct_lru #(
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_index,
    output logic             rd_next,
    input  logic             upd_en,
    input  logic [IDX_W-1:0] upd_index,
    input  logic             used_way
);
    localparam int SETS = 1 << IDX_W;

    logic [SETS-1:0] next_q;

    // Recency state: reset points every set at way 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            next_q <= '0;
        end else if (upd_en) begin
            next_q[upd_index] <= ~used_way;
        end
    end

    // Read port for the victim selector.
    assign rd_next = next_q[rd_index];
endmodule

// File: rtl/dct_victim_sel.sv
// Picks the way to replace among unlocked ways of a two-way set.
// With both ways locked, alloc is 0 and the way output is don't-care.
module dct_victim_sel (
    input  logic [1:0] lock,
    input  logic       lru_next,
    output logic       way,
    output logic       alloc
);
    // Locks override recency; recency decides when both ways are free.
    always_comb begin
        alloc = ~(lock[0] & lock[1]);
        if (lock[0])      way = 1'b1;
        else if (lock[1]) way = 1'b0;
        else              way = lru_next;
    end
endmodule

// File: rtl/dcache_tag_ctrl.sv
// Tag and control section of a two-way set-associative data cache.
// Virtually indexed, physically tagged; per-access write policy; per-way lock.
// Assumes one request at a time: a request is taken only while ready is 1,
// and fill_done is pulsed by the refill engine only while fill_req is high.
module dcache_tag_ctrl
    import dct_pkg::*;
#(
    parameter int IDX_W = 4,
    parameter int TAG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lock_we,
    input  logic [1:0]       lock_wdata,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic             req_wt,
    input  logic [IDX_W-1:0] req_index,
    input  logic [TAG_W-1:0] req_tag,
    output logic             ready,
    output logic             resp_valid,
    output logic             resp_hit,
    output logic             resp_way,
    output logic             bus_wr,
    output logic             wb_req,
    output logic [TAG_W-1:0] wb_tag,
    output logic [IDX_W-1:0] wb_index,
    output logic             fill_req,
    output logic [TAG_W-1:0] fill_tag,
    output logic [IDX_W-1:0] fill_index,
    output logic             fill_way,
    output logic             fill_alloc,
    input  logic             fill_done
);
    dct_state_e       state_q;
    logic [1:0]       lock_q;
    logic [IDX_W-1:0] lat_index;
    logic [TAG_W-1:0] lat_tag;
    logic [TAG_W-1:0] lat_vtag;
    logic             lat_write, lat_wt, lat_way, lat_alloc;

    logic [NUM_WAYS-1:0] way_hit, way_dirty;
    logic [TAG_W-1:0]    way_tag [NUM_WAYS];
    logic                accept, any_hit, hit_way, fill_fire;
    logic                lru_next, vic_way, vic_alloc;
    logic                lru_upd, lru_way;
    logic [IDX_W-1:0]    lru_idx;

    assign accept    = req_valid && (state_q == ST_IDLE);
    assign fill_fire = (state_q == ST_FILL) && fill_done;
    assign any_hit   = |way_hit;
    assign hit_way   = way_hit[1];

    // One tag store per way; installs go to the latched victim way only.
    for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
        dct_tag_way #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_way (
            .clk        (clk),
            .rst_n      (rst_n),
            .look_index (req_index),
            .look_tag   (req_tag),
            .look_hit   (way_hit[w]),
            .look_dirty (way_dirty[w]),
            .look_tag_q (way_tag[w]),
            .inst_en    (fill_fire && lat_alloc && (lat_way == 1'(w))),
            .inst_index (lat_index),
            .inst_tag   (lat_tag),
            .inst_dirty (lat_write && !lat_wt),
            .mark_en    (accept && way_hit[w] && req_write && !req_wt)
        );
    end

    // Recency is touched by hits at accept time and by installs at fill time.
    assign lru_upd = (accept && any_hit) || (fill_fire && lat_alloc);
    assign lru_idx = accept ? req_index : lat_index;
    assign lru_way = accept ? hit_way : lat_way;

    dct_lru #(.IDX_W(IDX_W)) u_lru (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_index  (req_index),
        .rd_next   (lru_next),
        .upd_en    (lru_upd),
        .upd_index (lru_idx),
        .used_way  (lru_way)
    );

    dct_victim_sel u_vsel (
        .lock     (lock_q),
        .lru_next (lru_next),
        .way      (vic_way),
        .alloc    (vic_alloc)
    );

    // Lock register: software-programmed, deliberately untouched by reset.
    always_ff @(posedge clk) begin
        if (lock_we) begin
            lock_q <= lock_wdata;
        end
    end

    // Control sequence: lookup, optional writeback, refill, release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            resp_valid <= 1'b0;
            resp_hit   <= 1'b0;
            resp_way   <= 1'b0;
            bus_wr     <= 1'b0;
            lat_index  <= '0;
            lat_tag    <= '0;
            lat_vtag   <= '0;
            lat_write  <= 1'b0;
            lat_wt     <= 1'b0;
            lat_way    <= 1'b0;
            lat_alloc  <= 1'b0;
        end else begin
            resp_valid <= 1'b0;
            bus_wr     <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        bus_wr    <= req_write && req_wt;
                        lat_index <= req_index;
                        lat_tag   <= req_tag;
                        lat_write <= req_write;
                        lat_wt    <= req_wt;
                        if (any_hit) begin
                            resp_valid <= 1'b1;
                            resp_hit   <= 1'b1;
                            resp_way   <= hit_way;
                        end else begin
                            resp_hit  <= 1'b0;
                            lat_way   <= vic_way;
                            lat_alloc <= vic_alloc;
                            lat_vtag  <= way_tag[vic_way];
                            state_q   <= (vic_alloc && way_dirty[vic_way]) ? ST_WB : ST_FILL;
                        end
                    end
                end
                ST_WB: begin
                    state_q <= ST_FILL;
                end
                ST_FILL: begin
                    if (fill_done) begin
                        state_q    <= ST_IDLE;
                        resp_valid <= 1'b1;
                        resp_hit   <= 1'b0;
                        resp_way   <= lat_way;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Request outputs follow the state and latched miss context.
    assign ready      = (state_q == ST_IDLE);
    assign wb_req     = (state_q == ST_WB);
    assign wb_tag     = lat_vtag;
    assign wb_index   = lat_index;
    assign fill_req   = (state_q == ST_FILL);
    assign fill_tag   = lat_tag;
    assign fill_index = lat_index;
    assign fill_way   = lat_way;
    assign fill_alloc = lat_alloc;
endmodule

// File: rtl/dct_chk.sv
// Protocol checker for dcache_tag_ctrl, attached by bind below.
module dct_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ready,
    input logic       req_valid,
    input logic       req_write,
    input logic       req_wt,
    input logic       wb_req,
    input logic       fill_req,
    input logic       fill_done,
    input logic       fill_alloc,
    input logic       fill_way,
    input logic [1:0] lock_q,
    input logic       bus_wr,
    input logic       resp_valid
);
    // R9
    wb_then_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_req |=> (fill_req && !wb_req));

    // R9
    wb_fill_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wb_req && fill_req));

    // R5
    locked_victim_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_req && fill_alloc) |-> !lock_q[fill_way]);

    // R10
    fill_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_req && !fill_done) |=> fill_req);

    // R10
    fill_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_req && fill_done) |=> (resp_valid && ready && !fill_req));

    // R8
    bus_wr_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr |-> $past(req_valid && ready && req_write && req_wt));

    // R11
    busy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |=> !bus_wr);
endmodule

bind dcache_tag_ctrl dct_chk u_dct_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ready      (ready),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_wt     (req_wt),
    .wb_req     (wb_req),
    .fill_req   (fill_req),
    .fill_done  (fill_done),
    .fill_alloc (fill_alloc),
    .fill_way   (fill_way),
    .lock_q     (lock_q),
    .bus_wr     (bus_wr),
    .resp_valid (resp_valid)
);

// File: tb/test_dcache_tag_ctrl.sv
module test_dcache_tag_ctrl;
    localparam int IDX_W = 4;
    localparam int TAG_W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lock_we = 1'b0;
    logic [1:0] lock_wdata = 2'b00;
    logic req_valid = 1'b0, req_write = 1'b0, req_wt = 1'b0;
    logic [IDX_W-1:0] req_index = '0;
    logic [TAG_W-1:0] req_tag = '0;
    logic fill_done = 1'b0;
    logic ready, resp_valid, resp_hit, resp_way, bus_wr;
    logic wb_req, fill_req, fill_way, fill_alloc;
    logic [TAG_W-1:0] wb_tag, fill_tag;
    logic [IDX_W-1:0] wb_index, fill_index;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    dcache_tag_ctrl #(.IDX_W(IDX_W), .TAG_W(TAG_W)) i_dcache_tag_ctrl (
        .clk(clk), .rst_n(rst_n), .lock_we(lock_we), .lock_wdata(lock_wdata),
        .req_valid(req_valid), .req_write(req_write), .req_wt(req_wt),
        .req_index(req_index), .req_tag(req_tag), .ready(ready),
        .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_way(resp_way),
        .bus_wr(bus_wr), .wb_req(wb_req), .wb_tag(wb_tag), .wb_index(wb_index),
        .fill_req(fill_req), .fill_tag(fill_tag), .fill_index(fill_index),
        .fill_way(fill_way), .fill_alloc(fill_alloc), .fill_done(fill_done)
    );

    typedef struct packed {
        logic       w;
        logic       wt;
        logic [3:0] idx;
        logic [7:0] tag;
        logic       ehit;
        logic       eway;
        logic       ewb;
        logic [7:0] ewbtag;
        logic       ealloc;
        logic [3:0] rq;
    } vec_t;

    // Walk of one set with changing tags; rq names the main requirement.
    localparam vec_t VECS [13] = '{
        '{1'b0, 1'b0, 4'd1, 8'hA0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 4'd1},  // R1 cold miss, R4 way 0
        '{1'b0, 1'b0, 4'd1, 8'hA0, 1'b1, 1'b0, 1'b0, 8'h00, 1'b1, 4'd2},  // R2 hit
        '{1'b1, 1'b0, 4'd1, 8'hB0, 1'b0, 1'b1, 1'b0, 8'h00, 1'b1, 4'd4},  // R4 other way, R7 dirty install
        '{1'b0, 1'b0, 4'd1, 8'hB0, 1'b1, 1'b1, 1'b0, 8'h00, 1'b1, 4'd2},  // R2 hit way 1
        '{1'b0, 1'b0, 4'd2, 8'hA0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 4'd3},  // R3 same tag, other set
        '{1'b0, 1'b0, 4'd1, 8'hC0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 4'd4},  // R4 hit moved victim to way 0
        '{1'b0, 1'b0, 4'd1, 8'hD0, 1'b0, 1'b1, 1'b1, 8'hB0, 1'b1, 4'd7},  // R7 dirty eviction
        '{1'b1, 1'b1, 4'd1, 8'hD0, 1'b1, 1'b1, 1'b0, 8'h00, 1'b1, 4'd8},  // R8 wt write hit
        '{1'b0, 1'b0, 4'd1, 8'hE0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 4'd4},  // R4
        '{1'b0, 1'b0, 4'd1, 8'hF0, 1'b0, 1'b1, 1'b0, 8'h00, 1'b1, 4'd8},  // R8 wt line evicted clean
        '{1'b1, 1'b0, 4'd3, 8'h11, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 4'd7},  // R7 write-back write miss
        '{1'b1, 1'b1, 4'd3, 8'h22, 1'b0, 1'b1, 1'b0, 8'h00, 1'b1, 4'd8},  // R8 wt write miss
        '{1'b1, 1'b0, 4'd3, 8'h11, 1'b1, 1'b0, 1'b0, 8'h00, 1'b1, 4'd7}   // R7 write hit on dirty line
    };

    task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    // One access, from request through completion; checks at negedges.
    task automatic access(input string rq, input logic w, input logic wt,
                          input logic [3:0] idx, input logic [7:0] tag,
                          input logic ehit, input logic eway, input logic ewb,
                          input logic [7:0] ewbtag, input logic ealloc);
        @(negedge clk);
        chk(rq, "ready before request", ready, 1'b1);
        req_valid = 1'b1; req_write = w; req_wt = wt; req_index = idx; req_tag = tag;
        @(negedge clk);
        req_valid = 1'b0;
        chk(rq, "bus_wr after accept", bus_wr, w & wt);
        chk(rq, "resp_valid after lookup", resp_valid, ehit);
        if (ehit) begin
            chk(rq, "resp_hit", resp_hit, 1'b1);
            chk(rq, "resp_way", resp_way, eway);
            chk(rq, "no fill on hit", fill_req, 1'b0);
        end else begin
            chk(rq, "wb_req", wb_req, ewb);
            if (ewb) begin
                chk(rq, "wb_tag", wb_tag, ewbtag);
                chk(rq, "wb_index", wb_index, idx);
                chk(rq, "fill_req low during wb", fill_req, 1'b0);
                @(negedge clk);
                chk(rq, "wb_req single cycle", wb_req, 1'b0);
            end
            chk(rq, "fill_req", fill_req, 1'b1);
            chk(rq, "fill_alloc", fill_alloc, ealloc);
            if (ealloc) chk(rq, "fill_way", fill_way, eway);
            chk(rq, "fill_tag", fill_tag, tag);
            chk(rq, "fill_index", fill_index, idx);
            chk(rq, "ready low while busy", ready, 1'b0);
            @(negedge clk);
            chk("R10", "fill_req held", fill_req, 1'b1);
            fill_done = 1'b1;
            @(negedge clk);
            fill_done = 1'b0;
            chk("R10", "resp_valid after fill_done", resp_valid, 1'b1);
            chk("R10", "resp_hit after fill", resp_hit, 1'b0);
            chk("R10", "fill_req dropped", fill_req, 1'b0);
            chk("R10", "ready restored", ready, 1'b1);
        end
    endtask

    task automatic set_lock(input logic [1:0] v);
        @(negedge clk);
        lock_we = 1'b1; lock_wdata = v;
        @(negedge clk);
        lock_we = 1'b0;
    endtask

    initial begin
        // Lock register is not reset: program it while reset is held (R12).
        lock_we = 1'b1; lock_wdata = 2'b00;
        repeat (3) @(negedge clk);
        lock_we = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", "ready", ready, 1'b1);
        chk("R1", "resp_valid", resp_valid, 1'b0);
        chk("R1", "wb_req", wb_req, 1'b0);
        chk("R1", "fill_req", fill_req, 1'b0);
        chk("R1", "bus_wr", bus_wr, 1'b0);

        for (int i = 0; i < 13; i++) begin
            access($sformatf("R%0d", VECS[i].rq), VECS[i].w, VECS[i].wt, VECS[i].idx,
                   VECS[i].tag, VECS[i].ehit, VECS[i].eway, VECS[i].ewb,
                   VECS[i].ewbtag, VECS[i].ealloc);
        end

        // R5: way 0 locked; set 1 recency points at way 0, yet way 1 is replaced.
        set_lock(2'b01);
        access("R5", 1'b0, 1'b0, 4'd1, 8'h61, 1'b0, 1'b1, 1'b0, 8'h00, 1'b1);
        access("R5", 1'b0, 1'b0, 4'd1, 8'h62, 1'b0, 1'b1, 1'b0, 8'h00, 1'b1);
        access("R5", 1'b0, 1'b0, 4'd1, 8'hE0, 1'b1, 1'b0, 1'b0, 8'h00, 1'b1);

        // R5 with way 1 locked; set 3 recency points at way 1; way 0 is dirty (R7).
        set_lock(2'b10);
        access("R5", 1'b0, 1'b0, 4'd3, 8'h33, 1'b0, 1'b0, 1'b1, 8'h11, 1'b1);

        // R6: both ways locked; no install, repeat still misses, residents hit.
        set_lock(2'b11);
        access("R6", 1'b0, 1'b0, 4'd1, 8'h99, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0);
        access("R6", 1'b0, 1'b0, 4'd1, 8'h99, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0);
        access("R6", 1'b0, 1'b0, 4'd1, 8'hE0, 1'b1, 1'b0, 1'b0, 8'h00, 1'b1);

        // R11: request held high while busy is ignored.
        set_lock(2'b00);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_wt = 1'b0; req_index = 4'd5; req_tag = 8'h55;
        @(negedge clk);
        chk("R11", "miss started", fill_req, 1'b1);
        req_write = 1'b1; req_wt = 1'b1; req_tag = 8'h56;
        @(negedge clk);
        chk("R11", "no bus_wr while busy", bus_wr, 1'b0);
        chk("R11", "no response while busy", resp_valid, 1'b0);
        @(negedge clk);
        chk("R11", "no bus_wr while busy", bus_wr, 1'b0);
        chk("R11", "fill tag unchanged", fill_tag, 8'h55);
        req_valid = 1'b0; fill_done = 1'b1;
        @(negedge clk);
        fill_done = 1'b0;
        chk("R11", "single completion", resp_valid, 1'b1);
        @(negedge clk);
        chk("R11", "no second completion", resp_valid, 1'b0);
        chk("R11", "no late bus_wr", bus_wr, 1'b0);
        access("R11", 1'b0, 1'b0, 4'd5, 8'h56, 1'b0, 1'b1, 1'b0, 8'h00, 1'b1);

        // R12 and R1: lock way 0, reset, then the old resident misses into way 1.
        set_lock(2'b01);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "ready after reset", ready, 1'b1);
        chk("R1", "fill_req after reset", fill_req, 1'b0);
        access("R12", 1'b0, 1'b0, 4'd1, 8'hE0, 1'b0, 1'b1, 1'b0, 8'h00, 1'b1);
        access("R1", 1'b0, 1'b0, 4'd3, 8'h11, 1'b0, 1'b1, 1'b0, 8'h00, 1'b1);

        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule